// File: doc/BRIEF.md
# Byte-Maskable Dual-Port RAM

This block is a synchronous RAM with two fully independent ports, A and B. Each port has its own clock and its own synchronous reset, and either port can read or write any word. Each word is made of 9-bit lanes. Every lane holds 8 data bits and 1 parity bit, and the parity bit is stored and returned exactly as the writer supplied it. A write can be limited to chosen lanes through per-lane enables. An address-hold input lets a port keep working on the address it registered earlier, whatever its address pins now carry.

The default build has 512 words of one lane, which gives 4,608 bits: 4,096 data bits plus 512 parity bits. Each port registers its address, write strobe, lane enables and write data on one clock edge. On the next edge of the same clock, the port performs the write and captures the read data. The RAM is a memory array and not a stream endpoint, so the ports are plain synchronous pins with no valid/ready handshake. A request is accepted on every edge, and a port never applies back-pressure.

If both ports write the same word while their write windows overlap, the stored value is undefined. Users must avoid this case.

Top module: `bm_dpram`

## Requirements
- R1: The array holds 2^ADDR_W words of LANES lanes. Every address can be written and then read back through either port.
- R2: Lane l occupies word bits [9l+8 : 9l]. Bit 9l+8 is that lane's parity bit, and it is stored and returned unchanged, in the same way as the data bits.
- R3: The address is registered on clock edge N, and read data appears after edge N+1 of the same port's clock. If a port writes a word and reads it in the same operation, the read returns the value held before the write.
- R4: A write changes lane l only when the write strobe and lane enable l are both high. Lanes whose enable is low keep their data and their parity bit. When the write strobe is low, nothing is written, whatever the lane enables are.
- R5: While hold is high at a port's clock edge, that port's registered address does not change. Both reads and writes use the held address, and new address inputs are ignored.
- R6: The two ports are symmetrical. Each can read or write on its own clock, and operations on the two ports that target different words do not interfere.
- R7: A write made on one port is returned by a read on the other port, provided the other port registers its address after the write has completed.
- R8: While a port's reset is low, its read data is zero. Reset does not change the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous reset, active low |
| addr_a | input | ADDR_W | Port A word address |
| hold_a | input | 1 | Port A address hold |
| we_a | input | 1 | Port A write strobe |
| be_a | input | LANES | Port A lane write enables |
| wdata_a | input | 9*LANES | Port A write data (data plus parity per lane) |
| rdata_a | output | 9*LANES | Port A read data |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous reset, active low |
| addr_b | input | ADDR_W | Port B word address |
| hold_b | input | 1 | Port B address hold |
| we_b | input | 1 | Port B write strobe |
| be_b | input | LANES | Port B lane write enables |
| wdata_b | input | 9*LANES | Port B write data (data plus parity per lane) |
| rdata_b | output | 9*LANES | Port B read data |

## Verification
Two pairs of events can fall on the same edge.

The first pair is a port's own write and its read of the same word. Every write operation in the bench also returns read data. That data is compared with the bench's shadow copy taken before the write is applied, so it must show the old word.

The second pair is activity on the two ports. In a forked phase, both ports run random reads and masked writes at the same time on unrelated clocks, each port confined to its own half of the address space. Every result is judged against the shared shadow model. A final sweep from the opposite port then confirms that no word was disturbed.

// File: rtl/bm_dpram_pkg.sv
package bm_dpram_pkg;
  localparam int unsigned DATA_BITS = 8;
  localparam int unsigned LANE_W    = DATA_BITS + 1;

  function automatic int unsigned word_width(input int unsigned lanes);
    return lanes * LANE_W;
  endfunction
endpackage

// File: rtl/bm_dpram_inreg.sv
module bm_dpram_inreg
  import bm_dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LANES  = 1,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hold,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic              we_q,
  output logic [LANES-1:0]  be_q,
  output logic [WORD_W-1:0] wdata_q
);

  always_ff @(posedge clk) begin
    if (!hold) addr_q <= addr;
    be_q    <= be;
    wdata_q <= wdata;
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= we;
  end

  // R5: a fresh address is taken when hold is low
  p_addr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (addr_q == $past(addr)));

  // R5: the registered address is frozen while hold is high
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(addr_q));

endmodule

// File: rtl/bm_dpram_bank.sv
module bm_dpram_bank
  import bm_dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LANES  = 1,
  parameter bit          FLIP   = 1'b0,
  localparam int unsigned WORD_W = LANES * LANE_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  flag_peer,
  input  logic [ADDR_W-1:0] raddr0,
  input  logic [ADDR_W-1:0] raddr1,
  output logic [WORD_W-1:0] rdata0,
  output logic [WORD_W-1:0] rdata1,
  output logic [LANES-1:0]  rflag0,
  output logic [LANES-1:0]  rflag1
);

  logic [WORD_W-1:0] mem  [DEPTH];
  logic [LANES-1:0]  flag [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (be[l]) begin
          mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
          flag[waddr][l]                 <= flag_peer[l] ^ FLIP;
        end
      end
    end
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];
  assign rflag0 = flag[raddr0];
  assign rflag1 = flag[raddr1];

  // R4: with the strobe low the addressed word is untouched
  p_idle_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (mem[$past(waddr)] == $past(mem[waddr])));

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
      // R4: a disabled lane keeps data and parity through a write
      p_mask_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !be[g]) |=>
          (mem[$past(waddr)][g*LANE_W +: LANE_W] == $past(mem[waddr][g*LANE_W +: LANE_W])));
    end
  endgenerate

endmodule

// File: rtl/bm_dpram_rdport.sv
module bm_dpram_rdport
  import bm_dpram_pkg::*;
#(
  parameter int unsigned LANES = 1,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] a_data,
  input  logic [LANES-1:0]  a_flag,
  input  logic [WORD_W-1:0] b_data,
  input  logic [LANES-1:0]  b_flag,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] picked;

  // matching flags mean port A wrote the lane last, differing flags mean port B
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      picked[l*LANE_W +: LANE_W] = (a_flag[l] == b_flag[l]) ? a_data[l*LANE_W +: LANE_W]
                                                            : b_data[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= picked;
  end

endmodule

// File: rtl/bm_dpram.sv
module bm_dpram
  import bm_dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LANES  = 1,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic              hold_a,
  input  logic              we_a,
  input  logic [LANES-1:0]  be_a,
  input  logic [WORD_W-1:0] wdata_a,
  output logic [WORD_W-1:0] rdata_a,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              hold_b,
  input  logic              we_b,
  input  logic [LANES-1:0]  be_b,
  input  logic [WORD_W-1:0] wdata_b,
  output logic [WORD_W-1:0] rdata_b
);

  logic [ADDR_W-1:0] aq_a, aq_b;
  logic              wq_a, wq_b;
  logic [LANES-1:0]  bq_a, bq_b;
  logic [WORD_W-1:0] dq_a, dq_b;

  logic [WORD_W-1:0] ba_d0, ba_d1, bb_d0, bb_d1;
  logic [LANES-1:0]  ba_f0, ba_f1, bb_f0, bb_f1;

  bm_dpram_inreg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_in_a (
    .clk(clk_a), .rst_n(rst_a_n), .addr(addr_a), .hold(hold_a), .we(we_a),
    .be(be_a), .wdata(wdata_a), .addr_q(aq_a), .we_q(wq_a), .be_q(bq_a), .wdata_q(dq_a));

  bm_dpram_inreg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_in_b (
    .clk(clk_b), .rst_n(rst_b_n), .addr(addr_b), .hold(hold_b), .we(we_b),
    .be(be_b), .wdata(wdata_b), .addr_q(aq_b), .we_q(wq_b), .be_q(bq_b), .wdata_q(dq_b));

  // bank A: written only by port A; its flag copies port B's flag
  bm_dpram_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .FLIP(1'b0)) u_bank_a (
    .clk(clk_a), .rst_n(rst_a_n), .we(wq_a), .be(bq_a), .waddr(aq_a), .wdata(dq_a),
    .flag_peer(bb_f0), .raddr0(aq_a), .raddr1(aq_b),
    .rdata0(ba_d0), .rdata1(ba_d1), .rflag0(ba_f0), .rflag1(ba_f1));

  // bank B: written only by port B; its flag inverts port A's flag
  bm_dpram_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .FLIP(1'b1)) u_bank_b (
    .clk(clk_b), .rst_n(rst_b_n), .we(wq_b), .be(bq_b), .waddr(aq_b), .wdata(dq_b),
    .flag_peer(ba_f1), .raddr0(aq_a), .raddr1(aq_b),
    .rdata0(bb_d0), .rdata1(bb_d1), .rflag0(bb_f0), .rflag1(bb_f1));

  bm_dpram_rdport #(.LANES(LANES)) u_rd_a (
    .clk(clk_a), .rst_n(rst_a_n), .a_data(ba_d0), .a_flag(ba_f0),
    .b_data(bb_d0), .b_flag(bb_f0), .rdata(rdata_a));

  bm_dpram_rdport #(.LANES(LANES)) u_rd_b (
    .clk(clk_b), .rst_n(rst_b_n), .a_data(ba_d1), .a_flag(ba_f1),
    .b_data(bb_d1), .b_flag(bb_f1), .rdata(rdata_b));

endmodule

// File: tb/bm_dpram_tb.sv
module bm_dpram_tb;
  localparam int unsigned AW    = 8;
  localparam int unsigned LN    = 2;
  localparam int unsigned WW    = LN * 9;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk_a = 1'b0, clk_b = 1'b0;
  logic          rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic          hold_a = 1'b0, hold_b = 1'b0, we_a = 1'b0, we_b = 1'b0;
  logic [LN-1:0] be_a = '0, be_b = '0;
  logic [WW-1:0] wdata_a = '0, wdata_b = '0;
  logic [WW-1:0] rdata_a, rdata_b;

  logic [WW-1:0] shadow [DEPTH];
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #4 clk_a = ~clk_a;   // 125 MHz
  always #7 clk_b = ~clk_b;

  bm_dpram #(.ADDR_W(AW), .LANES(LN)) u_dut (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .addr_a(addr_a), .hold_a(hold_a), .we_a(we_a),
    .be_a(be_a), .wdata_a(wdata_a), .rdata_a(rdata_a),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .addr_b(addr_b), .hold_b(hold_b), .we_b(we_b),
    .be_b(be_b), .wdata_b(wdata_b), .rdata_b(rdata_b));

  function automatic logic [WW-1:0] merge(input logic [WW-1:0] old, input logic [WW-1:0] nw,
                                          input logic we, input logic [LN-1:0] be);
    logic [WW-1:0] r = old;
    if (we)
      for (int l = 0; l < LN; l++)
        if (be[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [WW-1:0] act,
                       input logic [WW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // one operation on a port; returns the read data captured one edge later
  task automatic op(input bit pb, input logic [AW-1:0] ad, input logic hd, input logic we,
                    input logic [LN-1:0] be, input logic [WW-1:0] wd, output logic [WW-1:0] rd);
    if (pb) begin
      @(negedge clk_b); addr_b = ad; hold_b = hd; we_b = we; be_b = be; wdata_b = wd;
      @(negedge clk_b); we_b = 1'b0; hold_b = 1'b0;
      @(negedge clk_b); rd = rdata_b;
    end else begin
      @(negedge clk_a); addr_a = ad; hold_a = hd; we_a = we; be_a = be; wdata_a = wd;
      @(negedge clk_a); we_a = 1'b0; hold_a = 1'b0;
      @(negedge clk_a); rd = rdata_a;
    end
  endtask

  // random checked traffic; hi selects the address half when split is set
  task automatic rand_ops(input bit pb, input int n, input bit split, input bit hi);
    logic [WW-1:0] rd, wd, expv;
    logic [AW-1:0] ad;
    logic we;
    logic [LN-1:0] be;
    for (int i = 0; i < n; i++) begin
      ad = AW'($urandom);
      if (split) ad[AW-1] = hi;
      we = 1'($urandom);
      be = LN'($urandom);
      wd = WW'($urandom);
      expv = shadow[ad];
      op(pb, ad, 1'b0, we, be, wd, rd);
      check(rd == expv, pb ? "R6 port B random" : "R6 port A random", rd, expv);
      shadow[ad] = merge(shadow[ad], wd, we, be);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_a);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] rd, wd;
    void'($urandom(32'd1234));

    // R8: read data is zero while reset is low
    repeat (4) @(negedge clk_b);
    check(rdata_a == '0, "R8 reset rdata_a", rdata_a, '0);
    check(rdata_b == '0, "R8 reset rdata_b", rdata_b, '0);
    rst_a_n = 1'b1; rst_b_n = 1'b1;

    // R1: fill every word from A, sweep it back from B (R7 cross-port)
    for (int i = 0; i < DEPTH; i++) begin
      wd = WW'($urandom);
      op(1'b0, AW'(i), 1'b0, 1'b1, '1, wd, rd);
      shadow[i] = wd;
    end
    for (int i = 0; i < DEPTH; i++) begin
      op(1'b1, AW'(i), 1'b0, 1'b0, '0, '0, rd);
      check(rd == shadow[i], "R1 R7 fill and sweep", rd, shadow[i]);
    end

    // R2: parity bits alone set, data zero
    wd = {1'b1, 8'h00, 1'b1, 8'h00};
    op(1'b0, 8'd5, 1'b0, 1'b1, 2'b11, wd, rd);
    shadow[5] = wd;
    op(1'b1, 8'd5, 1'b0, 1'b0, 2'b00, '0, rd);
    check(rd == wd, "R2 parity stored", rd, wd);

    // R3: read during own write returns old word, then new word
    wd = 18'h2A5C3;
    op(1'b0, 8'd7, 1'b0, 1'b1, 2'b11, wd, rd);
    check(rd == shadow[7], "R3 read-before-write", rd, shadow[7]);
    shadow[7] = wd;
    op(1'b0, 8'd7, 1'b0, 1'b0, 2'b00, '0, rd);
    check(rd == wd, "R3 new data next read", rd, wd);

    // R4: upper lane masked, its parity kept
    wd = 18'h3FFFF;
    op(1'b0, 8'd9, 1'b0, 1'b1, 2'b01, wd, rd);
    shadow[9] = merge(shadow[9], wd, 1'b1, 2'b01);
    op(1'b0, 8'd9, 1'b0, 1'b0, 2'b00, '0, rd);
    check(rd == shadow[9], "R4 lane 1 masked", rd, shadow[9]);
    // R4: lower lane masked
    wd = 18'h00000;
    op(1'b1, 8'd9, 1'b0, 1'b1, 2'b10, wd, rd);
    shadow[9] = merge(shadow[9], wd, 1'b1, 2'b10);
    op(1'b1, 8'd9, 1'b0, 1'b0, 2'b00, '0, rd);
    check(rd == shadow[9], "R4 lane 0 masked", rd, shadow[9]);
    // R4: strobe low with enables high writes nothing
    op(1'b0, 8'd9, 1'b0, 1'b0, 2'b11, 18'h12345, rd);
    op(1'b0, 8'd9, 1'b0, 1'b0, 2'b00, '0, rd);
    check(rd == shadow[9], "R4 strobe low no write", rd, shadow[9]);
    // R4: strobe high with no enables writes nothing
    op(1'b0, 8'd9, 1'b0, 1'b1, 2'b00, 18'h12345, rd);
    op(1'b0, 8'd9, 1'b0, 1'b0, 2'b00, '0, rd);
    check(rd == shadow[9], "R4 no lanes enabled", rd, shadow[9]);

    // R5: held address used for a read
    op(1'b0, 8'd20, 1'b0, 1'b0, 2'b00, '0, rd);
    op(1'b0, 8'd30, 1'b1, 1'b0, 2'b00, '0, rd);
    check(rd == shadow[20], "R5 held read", rd, shadow[20]);
    // R5: held address used for a write
    op(1'b1, 8'd40, 1'b0, 1'b0, 2'b00, '0, rd);
    wd = 18'h15A5A;
    op(1'b1, 8'd50, 1'b1, 1'b1, 2'b11, wd, rd);
    shadow[40] = wd;
    op(1'b1, 8'd40, 1'b0, 1'b0, 2'b00, '0, rd);
    check(rd == shadow[40], "R5 held write landed", rd, shadow[40]);
    op(1'b1, 8'd50, 1'b0, 1'b0, 2'b00, '0, rd);
    check(rd == shadow[50], "R5 new address ignored", rd, shadow[50]);

    // R8: reset leaves contents intact
    @(negedge clk_a); rst_a_n = 1'b0;
    repeat (2) @(negedge clk_a);
    check(rdata_a == '0, "R8 rdata zero in reset", rdata_a, '0);
    rst_a_n = 1'b1;
    op(1'b0, 8'd7, 1'b0, 1'b0, 2'b00, '0, rd);
    check(rd == shadow[7], "R8 contents kept", rd, shadow[7]);

    // R6: random traffic on each port alone, then both at once on split halves
    rand_ops(1'b1, 300, 1'b0, 1'b0);
    rand_ops(1'b0, 300, 1'b0, 1'b0);
    fork
      rand_ops(1'b0, 400, 1'b1, 1'b0);
      rand_ops(1'b1, 300, 1'b1, 1'b1);
    join

    // R7: sweep everything from A after concurrent traffic
    for (int i = 0; i < DEPTH; i++) begin
      op(1'b0, AW'(i), 1'b0, 1'b0, '0, '0, rd);
      check(rd == shadow[i], "R7 final sweep", rd, shadow[i]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule